// File: doc/BRIEF.md
# JTAG Debug Resource Access Controller

This block is the test-clock side of a debug port. A sixteen-state machine follows the standard JTAG TAP sequence, driven by TMS on each rising edge of TCK. An 8-bit debug command register takes the place of the usual instruction register. Its select field picks which internal debug resource sits between TDI and TDO as the data register during the capture, shift and update steps of a data scan. There are three resources: a status register, a counter register and a program-counter trace register. Any select code that does not name one of them connects a one-bit bypass register.

The status register reports the CPU's halt state, so a debug host can check whether an access is safe before it makes it. The counter and trace registers are coupled to the CPU. They can be read at any time, but a write only lands while the CPU is halted in debug mode. A write that arrives while the CPU is running is dropped and leaves a sticky flag in the status register. The halt indication comes from the CPU clock domain and passes through a two-flop synchronizer in the TCK domain before the gate uses it.

Top module: `dbg_tap_ctrl`

## Requirements
- R1: The state machine follows the standard TAP transitions on TMS at each TCK rising edge. Five consecutive TCK rising edges with TMS high bring it to Test-Logic-Reset from any state.
- R2: A low level on trst_n immediately forces Test-Logic-Reset. It clears the command register, so bypass is selected and dbg_go is 0, and it clears tdo_en, the sticky flag, the synchronizer, cnt_q and trace_q. Entering Test-Logic-Reset through TMS also clears the command register.
- R3: The command register is 8 bits, shifted LSB first through TDI in Shift-IR. Capture-IR loads 8'h01 into the IR shift stage, so the first eight bits shifted out are 1,0,0,0,0,0,0,0. The command register changes only in Update-IR.
- R4: Command fields: bit 7 = 1 selects a read and 0 selects a write. Bit 6 appears on dbg_go. Bits 4:0 select the resource: 5'h01 is the 8-bit status register, 5'h02 is the 16-bit counter, 5'h03 is the 32-bit trace register.
- R5: The selected resource is loaded into the DR shift stage in Capture-DR. It is then shifted LSB first, and TDI enters at the resource's top bit, so after exactly its length in bits the captured value has been shifted out.
- R6: Any other select code connects a one-bit bypass register that captures 0, so TDO replays TDI delayed by one bit.
- R7: Reads of the status, counter and trace registers return their current values whether or not the CPU is halted.
- R8: In Update-DR, a write command to the counter or trace register updates it from the shift stage only when the synchronized halt input is 1. Otherwise the register keeps its value.
- R9: Status register: bit 0 is the synchronized halt state and bit 1 is the sticky write-rejected flag. All other bits read 0. A write rejected under R8 sets bit 1. Any write command to the status register clears bit 1.
- R10: cpu_halted reaches the gating logic through two TCK flops, so a change in cpu_halted is seen by the gate two rising edges later.
- R11: TDO and tdo_en change only on the TCK falling edge. tdo_en is 1 only in Shift-IR and Shift-DR, and tdo is 0 whenever tdo_en is 0.
- R12: An Update-DR under a read command writes nothing and leaves the counter, the trace register and the sticky flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on the TCK rising edge |
| tdi | input | 1 | Serial data in, LSB first |
| cpu_halted | input | 1 | CPU is halted in debug state (from the CPU clock domain) |
| tdo | output | 1 | Serial data out, updated on the TCK falling edge |
| tdo_en | output | 1 | TDO drive enable, high in Shift-IR and Shift-DR |
| dbg_go | output | 1 | Go/exit-debug request, bit 6 of the command register |
| cnt_q | output | CNT_W | Counter register contents |
| trace_q | output | TRC_W | Program-counter trace register contents |

## Verification
On every TCK edge the assertions check the following: the five-high TMS escape reaches Test-Logic-Reset; the command register holds outside Update-IR and Test-Logic-Reset; the gated registers stay stable while the synchronized halt is low; a rejected write raises the sticky flag; the synchronized halt lags its input by two edges; and TDO is enabled only in the shift states. Only the bench's scans can show what the cycle-level properties cannot. That covers the serial bit order and resource lengths, the Capture-IR pattern, the bypass delay, the data read back after accepted writes, the fact that read commands change nothing, and the recovery from TRST asserted in the middle of a scan. The scans use a model driven by random command sequences that include the halt state.

// File: rtl/dbg_tap_ctrl.sv
`timescale 1ns/1ps
module dbg_tap_ctrl #(
  parameter int IR_W   = 8,
  parameter int ST_W   = 8,
  parameter int CNT_W  = 16,
  parameter int TRC_W  = 32,
  parameter logic [4:0] SEL_STAT = 5'h01,
  parameter logic [4:0] SEL_CNT  = 5'h02,
  parameter logic [4:0] SEL_TRC  = 5'h03
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  input  logic             cpu_halted,
  output logic             tdo,
  output logic             tdo_en,
  output logic             dbg_go,
  output logic [CNT_W-1:0] cnt_q,
  output logic [TRC_W-1:0] trace_q
);

  localparam logic [IR_W-1:0] IR_CAPT = IR_W'(1);
  localparam int ST_PAD  = TRC_W - ST_W;
  localparam int CNT_PAD = TRC_W - CNT_W;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UPD_IR
  } tap_t;

  tap_t state, nxt;
  logic [IR_W-1:0]  cmd, ir_sr;
  logic [TRC_W-1:0] dr_sr;
  logic             sync1, halted_s, wr_rej;
  logic [2:0]       tms_run;

  wire [4:0] sel      = cmd[4:0];
  wire       is_read  = cmd[7];
  wire       hit_stat = (sel == SEL_STAT);
  wire       hit_cnt  = (sel == SEL_CNT);
  wire       hit_trc  = (sel == SEL_TRC);
  wire       gated    = hit_cnt | hit_trc;
  wire [ST_W-1:0] status = {{(ST_W-2){1'b0}}, wr_rej, halted_s};

  assign dbg_go = cmd[6];

  always_comb begin
    case (state)
      TLR:     nxt = tms ? TLR    : RTI;
      RTI:     nxt = tms ? SEL_DR : RTI;
      SEL_DR:  nxt = tms ? SEL_IR : CAP_DR;
      CAP_DR:  nxt = tms ? EX1_DR : SH_DR;
      SH_DR:   nxt = tms ? EX1_DR : SH_DR;
      EX1_DR:  nxt = tms ? UPD_DR : PA_DR;
      PA_DR:   nxt = tms ? EX2_DR : PA_DR;
      EX2_DR:  nxt = tms ? UPD_DR : SH_DR;
      UPD_DR:  nxt = tms ? SEL_DR : RTI;
      SEL_IR:  nxt = tms ? TLR    : CAP_IR;
      CAP_IR:  nxt = tms ? EX1_IR : SH_IR;
      SH_IR:   nxt = tms ? EX1_IR : SH_IR;
      EX1_IR:  nxt = tms ? UPD_IR : PA_IR;
      PA_IR:   nxt = tms ? EX2_IR : PA_IR;
      EX2_IR:  nxt = tms ? UPD_IR : SH_IR;
      UPD_IR:  nxt = tms ? SEL_DR : RTI;
      default: nxt = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= TLR;
    else         state <= nxt;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sync1    <= 1'b0;
      halted_s <= 1'b0;
    end else begin
      sync1    <= cpu_halted;
      halted_s <= sync1;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= '0;
      cmd   <= '0;
    end else begin
      case (state)
        TLR:     cmd   <= '0;
        CAP_IR:  ir_sr <= IR_CAPT;
        SH_IR:   ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        UPD_IR:  cmd   <= ir_sr;
        default: ;
      endcase
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      dr_sr <= '0;
    end else if (state == CAP_DR) begin
      if (hit_stat)     dr_sr <= {{ST_PAD{1'b0}}, status};
      else if (hit_cnt) dr_sr <= {{CNT_PAD{1'b0}}, cnt_q};
      else if (hit_trc) dr_sr <= trace_q;
      else              dr_sr <= '0;
    end else if (state == SH_DR) begin
      if (hit_stat)     dr_sr <= {{ST_PAD{1'b0}}, tdi, dr_sr[ST_W-1:1]};
      else if (hit_cnt) dr_sr <= {{CNT_PAD{1'b0}}, tdi, dr_sr[CNT_W-1:1]};
      else if (hit_trc) dr_sr <= {tdi, dr_sr[TRC_W-1:1]};
      else              dr_sr <= {{(TRC_W-1){1'b0}}, tdi};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      cnt_q   <= '0;
      trace_q <= '0;
      wr_rej  <= 1'b0;
    end else if (state == UPD_DR && !is_read) begin
      if (hit_stat) wr_rej <= 1'b0;
      else if (gated && !halted_s) wr_rej <= 1'b1;
      else if (hit_cnt) cnt_q   <= dr_sr[CNT_W-1:0];
      else if (hit_trc) trace_q <= dr_sr;
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (state == SH_IR) || (state == SH_DR);
      tdo    <= (state == SH_IR) ? ir_sr[0] : (state == SH_DR) ? dr_sr[0] : 1'b0;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)             tms_run <= '0;
    else if (!tms)           tms_run <= '0;
    else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
  end

  // R1
  tlr_escape_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (tms && tms_run >= 3'd4) |=> (state == TLR));

  // R3
  cmd_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state != UPD_IR && state != TLR) |=> $stable(cmd));

  // R8
  gate_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !halted_s |=> ($stable(cnt_q) && $stable(trace_q)));

  // R9
  reject_flag_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == UPD_DR && !is_read && gated && !halted_s) |=> wr_rej);

  // R10
  sync_lag_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(halted_s) |-> $past(cpu_halted, 2));

  // R11
  tdo_en_state_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state != SH_IR && state != SH_DR) |-> !tdo_en);

  // R11
  tdo_quiet_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !tdo_en |-> !tdo);

endmodule

// File: tb/dbg_tap_ctrl_test.sv
`timescale 1ns/1ps
module dbg_tap_ctrl_test;
  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, cpu_halted = 1'b0;
  logic tdo, tdo_en, dbg_go;
  logic [15:0] cnt_q;
  logic [31:0] trace_q;
  int compared = 0, mismatched = 0;

  dbg_tap_ctrl uut (.tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .cpu_halted(cpu_halted),
    .tdo(tdo), .tdo_en(tdo_en), .dbg_go(dbg_go), .cnt_q(cnt_q), .trace_q(trace_q));

  always #2 tck = ~tck;

  initial begin
    repeat (150000) @(posedge tck);
    mismatched++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck); #0.5;
    o = tdo; tms = m; tdi = d;
  endtask

  task automatic idle(input int n);
    logic x;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, x);
  endtask

  task automatic scan_ir(input logic [7:0] c, output logic [7:0] cap);
    logic x;
    step(1, 0, x); step(1, 0, x); step(0, 0, x); step(0, 0, x);
    for (int i = 0; i < 8; i++) begin
      step(i == 7, c[i], x);
      cap[i] = x;
    end
    step(1, 0, x); step(0, 0, x); step(0, 0, x);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout, output logic en);
    logic x;
    dout = '0;
    step(1, 0, x); step(0, 0, x); step(0, 0, x);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], x);
      dout[i] = x;
      if (i == 0) en = tdo_en;
    end
    step(1, 0, x); step(0, 0, x); step(0, 0, x);
  endtask

  function automatic int res_len(input logic [4:0] s);
    case (s)
      5'h01: return 8;
      5'h02: return 16;
      5'h03: return 32;
      default: return 8;
    endcase
  endfunction

  function automatic logic [31:0] len_mask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  logic [15:0] cnt_m;
  logic [31:0] trc_m;
  logic        rej_m, halt_m;

  function automatic logic [31:0] exp_out(input logic [4:0] s, input logic [31:0] din);
    case (s)
      5'h01: return {30'd0, rej_m, halt_m};
      5'h02: return {16'd0, cnt_m};
      5'h03: return trc_m;
      default: return {24'd0, din[6:0], 1'b0};
    endcase
  endfunction

  initial begin
    logic [7:0] irc;
    logic [31:0] dout, din;
    logic en, x;
    void'($urandom(32'd2024));
    cnt_m = '0; trc_m = '0; rej_m = 1'b0; halt_m = 1'b0;

    #9;
    chk("R2 reset tdo_en", {31'd0, tdo_en}, 32'd0);
    chk("R2 reset dbg_go", {31'd0, dbg_go}, 32'd0);
    chk("R2 reset cnt_q", {16'd0, cnt_q}, 32'd0);
    chk("R2 reset trace_q", trace_q, 32'd0);
    trst_n = 1'b1;
    idle(2);
    chk("R11 tdo_en idle", {31'd0, tdo_en}, 32'd0);

    scan_dr(8, 32'hFF, dout, en);
    chk("R6 bypass after reset", dout, 32'hFE);
    chk("R11 tdo_en in Shift-DR", {31'd0, en}, 32'd1);

    scan_ir(8'h81, irc);
    chk("R3 capture-IR pattern", {24'd0, irc}, 32'h01);
    scan_dr(8, 32'h00, dout, en);
    chk("R7 R9 status read running", dout, 32'h00);

    scan_ir(8'h02, irc);
    scan_dr(16, 32'hBEEF, dout, en);
    chk("R8 counter write blocked", {16'd0, cnt_q}, 32'd0);
    scan_ir(8'h81, irc);
    scan_dr(8, 32'h0, dout, en);
    chk("R9 sticky reject set", dout, 32'h02);
    scan_ir(8'h01, irc);
    scan_dr(8, 32'h0, dout, en);
    scan_ir(8'h81, irc);
    scan_dr(8, 32'h0, dout, en);
    chk("R9 sticky cleared by status write", dout, 32'h00);

    cpu_halted = 1'b1; idle(3);
    scan_dr(8, 32'h0, dout, en);
    chk("R10 R9 halt seen in status", dout, 32'h01);

    scan_ir(8'h02, irc);
    scan_dr(16, 32'hBEEF, dout, en);
    chk("R8 counter write halted", {16'd0, cnt_q}, 32'hBEEF);
    scan_ir(8'h03, irc);
    scan_dr(32, 32'hC0DE_1234, dout, en);
    chk("R8 trace write halted", trace_q, 32'hC0DE_1234);
    scan_ir(8'h82, irc);
    scan_dr(16, 32'h1111, dout, en);
    chk("R5 counter readback", dout, 32'hBEEF);
    chk("R12 read leaves counter", {16'd0, cnt_q}, 32'hBEEF);

    cpu_halted = 1'b0; idle(3);
    scan_ir(8'h83, irc);
    scan_dr(32, 32'h5555_AAAA, dout, en);
    chk("R7 trace read running", dout, 32'hC0DE_1234);
    chk("R12 read leaves trace", trace_q, 32'hC0DE_1234);

    scan_ir(8'hC1, irc);
    chk("R4 go bit", {31'd0, dbg_go}, 32'd1);
    step(1, 0, x); step(1, 0, x); step(0, 0, x); step(0, 0, x);
    for (int i = 0; i < 8; i++) step(i == 7, (i == 0), x);
    step(0, 0, x);
    chk("R3 command holds until Update-IR", {31'd0, dbg_go}, 32'd1);
    step(1, 0, x); step(1, 0, x); step(0, 0, x); step(0, 0, x);
    chk("R3 command updated", {31'd0, dbg_go}, 32'd0);

    scan_ir(8'hC3, irc);
    step(1, 0, x); step(0, 0, x); step(0, 0, x);
    for (int i = 0; i < 5; i++) step(1, 0, x);
    step(0, 0, x); step(0, 0, x);
    chk("R1 five TMS high clears command", {31'd0, dbg_go}, 32'd0);
    scan_dr(8, 32'h5A, dout, en);
    chk("R1 bypass after escape", dout, 32'hB4);

    scan_ir(8'hC3, irc);
    step(1, 0, x); step(0, 0, x); step(0, 0, x);
    @(negedge tck); #0.5 trst_n = 1'b0; #0.5;
    chk("R2 trst mid-scan dbg_go", {31'd0, dbg_go}, 32'd0);
    chk("R2 trst mid-scan tdo_en", {31'd0, tdo_en}, 32'd0);
    chk("R2 trst clears trace", trace_q, 32'd0);
    #2 trst_n = 1'b1; tms = 1'b1;
    idle(2);
    cnt_m = '0; trc_m = '0; rej_m = 1'b0; halt_m = 1'b0;

    for (int k = 0; k < 40; k++) begin
      logic [4:0] s;
      logic rd, go;
      int n;
      halt_m = $urandom_range(0, 1);
      cpu_halted = halt_m; idle(3);
      case ($urandom_range(0, 3))
        0: s = 5'h01;
        1: s = 5'h02;
        2: s = 5'h03;
        default: s = 5'($urandom_range(4, 31));
      endcase
      rd = $urandom_range(0, 1);
      go = $urandom_range(0, 1);
      din = $urandom;
      n = res_len(s);
      scan_ir({rd, go, 1'b0, s}, irc);
      chk("R3 random capture-IR", {24'd0, irc}, 32'h01);
      chk("R4 random go", {31'd0, dbg_go}, {31'd0, go});
      scan_dr(n, din, dout, en);
      chk("R5 R6 R7 random capture", dout, exp_out(s, din) & len_mask(n));
      if (!rd) begin
        if (s == 5'h01) rej_m = 1'b0;
        else if ((s == 5'h02 || s == 5'h03) && !halt_m) rej_m = 1'b1;
        else if (s == 5'h02) cnt_m = din[15:0];
        else if (s == 5'h03) trc_m = din;
      end
      chk("R8 R12 random counter", {16'd0, cnt_q}, {16'd0, cnt_m});
      chk("R8 R12 random trace", trace_q, trc_m);
    end
    scan_ir(8'h81, irc);
    scan_dr(8, 32'h0, dout, en);
    chk("R9 final status", dout, {30'd0, rej_m, halt_m});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule